// File: doc/BRIEF.md
# Banked SRAM with Per-Block Power Control

This block models an on-chip memory split into several independent sub-arrays that share one global data bus. Each incoming address is cut into a block field, a row field and a column field. The block field picks a single sub-array, and only that sub-array is woken for the access. Every other sub-array stays in a retention state: its decoders, bit-line precharge, word line and sense path are all held off, and its stored words are kept intact.

Every access is carried out by a small sequencer in the addressed sub-array. The sequencer spends exactly three cycles on each access.
- A read precharges the bit lines, then pulses the word line for a single cycle, then raises sense enable so the data can resolve. The word then appears on the global bus together with a one-cycle ready pulse.
- A write first drives the bit-line pair with the data and its complement, then pulses the word line while the drive is still held, then precharges the lines back.

A global sleep input holds off new requests, so all sub-arrays remain in retention. A request that arrives while sleep is high waits and is taken once sleep falls. Power states are flags only.

Top module: `banked_sram`

## Requirements
- R1: The address is laid out as {block, row, column}, with the block field in the most significant bits. With the defaults this is addr_i[7:6] block, addr_i[5:2] row and addr_i[1:0] column. After an accepted request, bit b of blk_active_o rises, where b is the block field, and no other bit rises.
- R2: At most one bit of blk_active_o is high in any cycle. blk_retain_o is the bitwise complement of blk_active_o.
- R3: A block whose blk_active_o bit is low keeps its pchg_o, wline_o, sense_o and wdrive_o bits at 0.
- R4: Accesses to one block, and periods of sleep, never change the words stored in any other block.
- R5: A read occupies three cycles after acceptance, in this order:
  - cycle 1: pchg_o=1, wline_o=0, sense_o=0
  - cycle 2: wline_o=1, pchg_o=0, sense_o=0
  - cycle 3: sense_o=1, wline_o=0, pchg_o=0
  - sense_o and pchg_o are never high together.
- R6: In each access, wline_o is high for exactly one cycle. It is never high in two consecutive cycles, and each rise follows a cycle with pchg_o or wdrive_o high.
- R7: In the cycle after the sense phase of a read, rdy_o is 1 and rdata_o holds the addressed word. rdy_o falls again in the following cycle.
- R8: A write occupies three cycles after acceptance, in this order:
  - cycle 1: wdrive_o=1, wline_o=0
  - cycle 2: wdrive_o=1, wline_o=1
  - cycle 3: pchg_o=1, wdrive_o=0, wline_o=0
  - A later read of the same address returns the written word. A write never raises rdy_o.
- R9: busy_o is 1 for the three cycles that follow acceptance and 0 otherwise. A request is accepted only at a clock edge where req_i=1, busy_o=0 and sleep_i=0. A request made while busy_o=1 is ignored.
- R10: While sleep_i=1, no request is accepted: busy_o stays 0 and blk_retain_o stays all ones. A request held through sleep is accepted at the first edge after sleep_i falls.
- R11: After reset, busy_o=0, rdy_o=0, blk_active_o=0, all phase outputs are 0 and blk_retain_o is all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_i | input | 1 | Global retention request; blocks new accesses |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W (8) | {block, row, column} address |
| wdata_i | input | DATA_W (8) | Write data |
| busy_o | output | 1 | Access in progress |
| rdy_o | output | 1 | One-cycle pulse: read data valid |
| rdata_o | output | DATA_W (8) | Global read data bus |
| blk_active_o | output | NUM_BLOCKS (4) | Per-block active flag |
| blk_retain_o | output | NUM_BLOCKS (4) | Per-block retention flag |
| pchg_o | output | NUM_BLOCKS (4) | Per-block bit-line precharge |
| wline_o | output | NUM_BLOCKS (4) | Per-block word-line pulse |
| sense_o | output | NUM_BLOCKS (4) | Per-block sense enable |
| wdrive_o | output | NUM_BLOCKS (4) | Per-block write bit-line drive |

## Verification
The assertions check the following on every cycle:
- at most one active block, with the retention flags as its complement;
- no phase activity in an inactive block;
- sense enable and precharge never high together;
- every word-line pulse lasts one cycle and is preceded by precharge or drive;
- every ready pulse follows a sense phase;
- no access starts from a cycle in which sleep was high.

Only the bench scenarios can show the remaining behaviour:
- the exact phase order for a read and for a write;
- the returned data values;
- that words in other blocks survive accesses and sleep;
- that a request is ignored while busy;
- that a request held through sleep is taken once sleep is released.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_PREP   = 2'd1,
    PH_WORD   = 2'd2,
    PH_FINISH = 2'd3
  } phase_t;
endpackage

// File: rtl/bsram_decode.sv
module bsram_decode #(
  parameter int NUM_BLOCKS = 4,
  parameter int BLK_W      = 2,
  parameter int ROW_W      = 4,
  parameter int COL_W      = 2,
  localparam int ADDR_W    = BLK_W + ROW_W + COL_W
) (
  input  logic [ADDR_W-1:0]     addr_i,
  output logic [NUM_BLOCKS-1:0] sel_oh_o,
  output logic [ROW_W-1:0]      row_o,
  output logic [COL_W-1:0]      col_o
);
  logic [BLK_W-1:0] blk;

  assign blk   = addr_i[ADDR_W-1 -: BLK_W];
  assign row_o = addr_i[COL_W +: ROW_W];
  assign col_o = addr_i[COL_W-1:0];

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_sel
    assign sel_oh_o[b] = (blk == BLK_W'(b));
  end
endmodule

// File: rtl/bsram_seq.sv
module bsram_seq
  import bsram_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic we_i,
  output logic act_o,
  output logic pc_o,
  output logic wl_o,
  output logic se_o,
  output logic drv_o,
  output logic capture_o,
  output logic commit_o,
  output logic done_o
);
  phase_t state, state_n;
  logic   op_we, we_n;

  always_comb begin
    state_n = state;
    unique case (state)
      PH_IDLE:   if (start_i) state_n = PH_PREP;
      PH_PREP:   state_n = PH_WORD;
      PH_WORD:   state_n = PH_FINISH;
      PH_FINISH: state_n = PH_IDLE;
      default:   state_n = PH_IDLE;
    endcase
  end

  assign we_n = (state == PH_IDLE && start_i) ? we_i : op_we;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= PH_IDLE;
      op_we <= 1'b0;
      act_o <= 1'b0;
      pc_o  <= 1'b0;
      wl_o  <= 1'b0;
      se_o  <= 1'b0;
      drv_o <= 1'b0;
    end else begin
      state <= state_n;
      op_we <= we_n;
      act_o <= (state_n != PH_IDLE);
      pc_o  <= (state_n == PH_PREP && !we_n) || (state_n == PH_FINISH && we_n);
      wl_o  <= (state_n == PH_WORD);
      se_o  <= (state_n == PH_FINISH && !we_n);
      drv_o <= (state_n == PH_PREP || state_n == PH_WORD) && we_n;
    end
  end

  assign capture_o = (state == PH_WORD) && !op_we;
  assign commit_o  = (state == PH_WORD) && op_we;
  assign done_o    = (state == PH_FINISH);
endmodule

// File: rtl/bsram_array.sv
module bsram_array #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[idx] <= wdata;
    if (rd_en) rdata <= mem[idx];
  end
endmodule

// File: rtl/banked_sram.sv
module banked_sram #(
  parameter int NUM_BLOCKS = 4,
  parameter int ROWS       = 16,
  parameter int COLS       = 4,
  parameter int DATA_W     = 8,
  localparam int BLK_W     = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
  localparam int ROW_W     = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int COL_W     = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int ADDR_W    = BLK_W + ROW_W + COL_W,
  localparam int DEPTH     = ROWS * COLS
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sleep_i,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic                  busy_o,
  output logic                  rdy_o,
  output logic [DATA_W-1:0]     rdata_o,
  output logic [NUM_BLOCKS-1:0] blk_active_o,
  output logic [NUM_BLOCKS-1:0] blk_retain_o,
  output logic [NUM_BLOCKS-1:0] pchg_o,
  output logic [NUM_BLOCKS-1:0] wline_o,
  output logic [NUM_BLOCKS-1:0] sense_o,
  output logic [NUM_BLOCKS-1:0] wdrive_o
);
  localparam int IDX_W = ROW_W + COL_W;

  logic [NUM_BLOCKS-1:0] sel_oh;
  logic [ROW_W-1:0]      dec_row;
  logic [COL_W-1:0]      dec_col;
  logic                  accept;

  logic [NUM_BLOCKS-1:0] req_blk_oh;
  logic [IDX_W-1:0]      req_idx;
  logic                  req_we;
  logic [DATA_W-1:0]     req_wd;

  logic [NUM_BLOCKS-1:0] capture, commit, done;
  logic [DATA_W-1:0]     bank_rd [NUM_BLOCKS];
  logic [DATA_W-1:0]     bus_mux;

  bsram_decode #(
    .NUM_BLOCKS(NUM_BLOCKS), .BLK_W(BLK_W), .ROW_W(ROW_W), .COL_W(COL_W)
  ) u_dec (
    .addr_i(addr_i), .sel_oh_o(sel_oh), .row_o(dec_row), .col_o(dec_col)
  );

  assign accept = req_i && !busy_o && !sleep_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o     <= 1'b0;
      req_blk_oh <= '0;
      req_idx    <= '0;
      req_we     <= 1'b0;
      req_wd     <= '0;
    end else if (accept) begin
      busy_o     <= 1'b1;
      req_blk_oh <= sel_oh;
      req_idx    <= {dec_row, dec_col};
      req_we     <= we_i;
      req_wd     <= wdata_i;
    end else if (|done) begin
      busy_o <= 1'b0;
    end
  end

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_bank
    bsram_seq u_seq (
      .clk(clk), .rst(rst),
      .start_i(accept && sel_oh[b]), .we_i(we_i),
      .act_o(blk_active_o[b]), .pc_o(pchg_o[b]), .wl_o(wline_o[b]),
      .se_o(sense_o[b]), .drv_o(wdrive_o[b]),
      .capture_o(capture[b]), .commit_o(commit[b]), .done_o(done[b])
    );

    bsram_array #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_arr (
      .clk(clk), .wr_en(commit[b]), .rd_en(capture[b]),
      .idx(req_idx), .wdata(req_wd), .rdata(bank_rd[b])
    );
  end

  assign blk_retain_o = ~blk_active_o;

  always_comb begin
    bus_mux = '0;
    for (int b = 0; b < NUM_BLOCKS; b++) begin
      if (req_blk_oh[b]) bus_mux = bus_mux | bank_rd[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_o   <= 1'b0;
      rdata_o <= '0;
    end else begin
      rdy_o <= (|done) && !req_we;
      if ((|done) && !req_we) rdata_o <= bus_mux;
    end
  end
endmodule

// File: rtl/bsram_checks.sv
module bsram_checks #(
  parameter int NUM_BLOCKS = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  sleep_i,
  input logic                  busy_o,
  input logic                  rdy_o,
  input logic [NUM_BLOCKS-1:0] blk_active_o,
  input logic [NUM_BLOCKS-1:0] blk_retain_o,
  input logic [NUM_BLOCKS-1:0] pchg_o,
  input logic [NUM_BLOCKS-1:0] wline_o,
  input logic [NUM_BLOCKS-1:0] sense_o,
  input logic [NUM_BLOCKS-1:0] wdrive_o
);
  AST_ONE_ACTIVE: assert property (@(posedge clk) disable iff (rst) $onehot0(blk_active_o)); // R2
  AST_RETAIN_COMPL: assert property (@(posedge clk) disable iff (rst) blk_retain_o == ~blk_active_o); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    ((pchg_o | wline_o | sense_o | wdrive_o) & ~blk_active_o) == '0); // R3
  AST_SENSE_NOT_PCHG: assert property (@(posedge clk) disable iff (rst) (sense_o & pchg_o) == '0); // R5
  AST_SENSE_AFTER_WL: assert property (@(posedge clk) disable iff (rst)
    (sense_o & ~$past(sense_o) & ~$past(wline_o)) == '0); // R5
  AST_WL_SINGLE: assert property (@(posedge clk) disable iff (rst) (wline_o & $past(wline_o)) == '0); // R6
  AST_WL_PREPARED: assert property (@(posedge clk) disable iff (rst)
    (wline_o & ~$past(wline_o) & ~$past(pchg_o | wdrive_o)) == '0); // R6
  AST_RDY_AFTER_SENSE: assert property (@(posedge clk) disable iff (rst) rdy_o |-> $past(|sense_o)); // R7
  AST_NO_WAKE_ASLEEP: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !$past(busy_o)) |-> !$past(sleep_i)); // R10
endmodule

bind banked_sram bsram_checks #(.NUM_BLOCKS(NUM_BLOCKS)) u_checks (
  .clk(clk), .rst(rst), .sleep_i(sleep_i), .busy_o(busy_o), .rdy_o(rdy_o),
  .blk_active_o(blk_active_o), .blk_retain_o(blk_retain_o),
  .pchg_o(pchg_o), .wline_o(wline_o), .sense_o(sense_o), .wdrive_o(wdrive_o)
);

// File: tb/banked_sram_test.sv
module banked_sram_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sleep_i = 1'b0;
  logic       req_i = 1'b0;
  logic       we_i = 1'b0;
  logic [7:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic       busy_o, rdy_o;
  logic [7:0] rdata_o;
  logic [3:0] blk_active_o, blk_retain_o, pchg_o, wline_o, sense_o, wdrive_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  banked_sram uut (
    .clk(clk), .rst(rst), .sleep_i(sleep_i), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .busy_o(busy_o), .rdy_o(rdy_o),
    .rdata_o(rdata_o), .blk_active_o(blk_active_o), .blk_retain_o(blk_retain_o),
    .pchg_o(pchg_o), .wline_o(wline_o), .sense_o(sense_o), .wdrive_o(wdrive_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mk(input int b, input int r, input int c);
    return {b[1:0], r[3:0], c[1:0]};
  endfunction

  // Full access with per-phase checks; request presented at a falling edge.
  task automatic access(input bit wr, input int b, input int r, input int c,
                        input logic [7:0] d, input logic [7:0] exp);
    logic [3:0] oh;
    oh = 4'b1 << b;
    req_i = 1'b1; we_i = wr; addr_i = mk(b, r, c); wdata_i = d;
    @(negedge clk);
    req_i = 1'b0;
    chk(blk_active_o == oh, "R1 active block", 32'(blk_active_o), 32'(oh));
    chk(blk_retain_o == ~oh, "R2 retain flags", 32'(blk_retain_o), 32'(~oh));
    chk(busy_o == 1'b1, "R9 busy phase1", 32'(busy_o), 32'd1);
    chk(((pchg_o | wline_o | sense_o | wdrive_o) & ~oh) == 4'b0, "R3 idle blocks quiet",
        32'(pchg_o | wline_o | sense_o | wdrive_o), 32'(oh));
    if (wr)
      chk(wdrive_o == oh && wline_o == 4'b0 && pchg_o == 4'b0, "R8 drive phase",
          32'({wdrive_o, wline_o, pchg_o}), 32'({oh, 4'b0, 4'b0}));
    else
      chk(pchg_o == oh && wline_o == 4'b0 && sense_o == 4'b0, "R5 precharge phase",
          32'({pchg_o, wline_o, sense_o}), 32'({oh, 4'b0, 4'b0}));
    @(negedge clk);
    if (wr)
      chk(wline_o == oh && wdrive_o == oh, "R8 word line with drive",
          32'({wline_o, wdrive_o}), 32'({oh, oh}));
    else
      chk(wline_o == oh && pchg_o == 4'b0 && sense_o == 4'b0, "R5 word line phase",
          32'({wline_o, pchg_o, sense_o}), 32'({oh, 4'b0, 4'b0}));
    @(negedge clk);
    chk(wline_o == 4'b0, "R6 word line one cycle", 32'(wline_o), 32'd0);
    chk(busy_o == 1'b1, "R9 busy phase3", 32'(busy_o), 32'd1);
    if (wr)
      chk(pchg_o == oh && wdrive_o == 4'b0, "R8 recover phase",
          32'({pchg_o, wdrive_o}), 32'({oh, 4'b0}));
    else
      chk(sense_o == oh && pchg_o == 4'b0, "R5 sense phase",
          32'({sense_o, pchg_o}), 32'({oh, 4'b0}));
    @(negedge clk);
    chk(busy_o == 1'b0 && blk_active_o == 4'b0, "R9 done idle",
        32'({busy_o, blk_active_o}), 32'd0);
    if (wr)
      chk(rdy_o == 1'b0, "R8 no ready on write", 32'(rdy_o), 32'd0);
    else begin
      chk(rdy_o == 1'b1, "R7 ready pulse", 32'(rdy_o), 32'd1);
      chk(rdata_o == exp, "R7 read data", 32'(rdata_o), 32'(exp));
    end
  endtask

  task automatic t_reset;
    @(negedge clk); @(negedge clk);
    chk(busy_o == 0 && rdy_o == 0 && blk_active_o == 0, "R11 reset idle",
        32'({busy_o, rdy_o, blk_active_o}), 32'd0);
    chk((pchg_o | wline_o | sense_o | wdrive_o) == 0, "R11 reset phases",
        32'(pchg_o | wline_o | sense_o | wdrive_o), 32'd0);
    chk(blk_retain_o == 4'hF, "R11 reset retain", 32'(blk_retain_o), 32'hF);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_fill_and_read;
    for (int b = 0; b < 4; b++) access(1'b1, b, 5, 2, 8'(8'h30 + b), 8'h0);
    for (int b = 3; b >= 0; b--) access(1'b0, b, 5, 2, 8'h0, 8'(8'h30 + b));
    @(negedge clk);
    chk(rdy_o == 1'b0, "R7 ready one cycle", 32'(rdy_o), 32'd0);
  endtask

  task automatic t_fields;
    access(1'b1, 1, 15, 3, 8'hA5, 8'h0);
    access(1'b1, 1, 0, 0, 8'h5A, 8'h0);
    access(1'b1, 1, 15, 0, 8'hC3, 8'h0);
    access(1'b0, 1, 15, 3, 8'h0, 8'hA5);
    access(1'b0, 1, 0, 0, 8'h0, 8'h5A);
    access(1'b0, 1, 15, 0, 8'h0, 8'hC3);
    access(1'b1, 1, 15, 3, 8'h11, 8'h0);
    access(1'b0, 1, 15, 3, 8'h0, 8'h11);
    // R4: other blocks still hold the fill values
    access(1'b0, 0, 5, 2, 8'h0, 8'h30);
    access(1'b0, 2, 5, 2, 8'h0, 8'h32);
  endtask

  task automatic t_busy_ignore;
    req_i = 1'b1; we_i = 1'b1; addr_i = mk(2, 5, 2); wdata_i = 8'hEE;
    @(negedge clk);
    addr_i = mk(3, 5, 2); wdata_i = 8'h99;
    @(negedge clk);
    chk(blk_active_o == 4'b0100, "R9 second request ignored", 32'(blk_active_o), 32'h4);
    @(negedge clk);
    req_i = 1'b0;
    @(negedge clk);
    chk(busy_o == 1'b0, "R9 busy clears", 32'(busy_o), 32'd0);
    access(1'b0, 3, 5, 2, 8'h0, 8'h33);
    access(1'b0, 2, 5, 2, 8'h0, 8'hEE);
  endtask

  task automatic t_sleep;
    sleep_i = 1'b1;
    req_i = 1'b1; we_i = 1'b1; addr_i = mk(0, 7, 1); wdata_i = 8'h77;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(busy_o == 1'b0 && blk_retain_o == 4'hF, "R10 held off in sleep",
          32'({busy_o, blk_retain_o}), 32'hF);
    end
    sleep_i = 1'b0;
    @(negedge clk);
    req_i = 1'b0;
    chk(blk_active_o == 4'b0001 && wdrive_o == 4'b0001, "R10 taken after wake",
        32'({blk_active_o, wdrive_o}), 32'h11);
    @(negedge clk); @(negedge clk); @(negedge clk);
    access(1'b0, 0, 7, 1, 8'h0, 8'h77);
    access(1'b0, 1, 15, 0, 8'h0, 8'hC3);
    access(1'b0, 3, 5, 2, 8'h0, 8'h33);
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_fill_and_read();
    t_fields();
    t_busy_ignore();
    t_sleep();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule